// File: doc/BRIEF.md
# Dual-Window Watchdog Supervisor

This block supervises a processor through three inputs (trigger, mode, wake-up) and drives an active-low reset request and an enable output. After a hardware reset or a synchronous power-on request it holds reset, then waits in a handshake state for the processor to pull mode low. From then on every trigger pulse must land inside an open window. A short window pair serves the active processor and a long window pair serves the sleeping one. Any violation produces a fixed-length reset pulse, after which the handshake restarts.

States and transitions: HOLD (power-up hold) leaves on timeout to HANDSHAKE. HANDSHAKE goes to SHORT_CLOSED when debounced mode is low, or to PULSE on timeout. SHORT_CLOSED goes to PULSE if the debounced trigger is low, to LONG_CLOSED if mode is high, and to SHORT_OPEN on timeout. SHORT_OPEN goes back to SHORT_CLOSED on a trigger rising edge. It goes to PULSE on an over-long trigger low or on timeout, and to LONG_CLOSED if mode is high. LONG_CLOSED goes to PULSE on a trigger low or a wake-up edge, to SHORT_CLOSED if mode is low, and to LONG_OPEN on timeout. LONG_OPEN goes to PULSE on a wake-up edge or timeout, to LONG_CLOSED on a trigger rising edge, and to SHORT_CLOSED if mode is low. PULSE returns to HANDSHAKE on timeout. A power-on request forces HOLD from any state. Each state change restarts a single shared timer.

All durations are parameters in clock cycles. Each input is debounced: a new level must be sampled on a number of consecutive cycles before it is accepted.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0 and `ena_out` is 0.
- R2: After `rst_n` rises, `rst_out_n` stays 0 for exactly T_POR clock edges and is 1 after the T_POR-th edge.
- R3: If debounced mode stays high in HANDSHAKE, `rst_out_n` falls on the T_MODESW-th edge after HANDSHAKE was entered.
- R4: A reset pulse keeps `rst_out_n` at 0 for exactly T_RSTOUT edges, after which the block is in HANDSHAKE. With mode already low it enters SHORT_CLOSED one edge later.
- R5: With no trigger, `rst_out_n` falls on the (T_SDIS+T_SEN)-th edge after SHORT_CLOSED was entered.
- R6: A debounced trigger low in SHORT_CLOSED causes PULSE on the next edge.
- R7: In SHORT_OPEN, a debounced trigger low lasting T_TRGMAX cycles followed by a rise is accepted. A low still present after T_TRGMAX counted cycles causes PULSE on the following edge.
- R8: `ena_out` is 1 only in the short states, and only after ENA_TRIGS consecutive accepted triggers in SHORT_OPEN. The count saturates and is cleared in HOLD and in PULSE.
- R9: Debounced mode high in a short state moves to LONG_CLOSED, where `ena_out` is 0. Debounced mode low in a long state moves to SHORT_CLOSED. The trigger count is kept across long mode.
- R10: With no trigger, `rst_out_n` falls on the (T_LDIS+T_LEN)-th edge after LONG_CLOSED was entered. A trigger rising edge in LONG_OPEN re-enters LONG_CLOSED and restarts that span.
- R11: A change of the debounced wake-up level causes PULSE on the next edge in LONG_CLOSED or LONG_OPEN. In any other state it has no effect.
- R12: `por_req` high at an edge forces HOLD with a fresh timer: `rst_out_n` is 0 after that edge and 1 after T_POR further edges.
- R13: Trigger and mode levels are accepted after DB_SHORT equal consecutive samples, and wake-up after DB_WAKE. A shorter excursion is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all durations count its rising edges |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| por_req | input | 1 | Synchronous power-on request, forces HOLD |
| trig_in | input | 1 | Trigger from the processor, idle high |
| mode_in | input | 1 | Mode from the processor, 1 selects the long window |
| wake_in | input | 1 | Wake-up request level |
| rst_out_n | output | 1 | Active-low reset to the processor |
| ena_out | output | 1 | Enable for peripheral safety circuitry |

## Verification
A change driven on trigger or mode reaches the state register on the (DB_SHORT+1)-th edge after it is applied: DB_SHORT edges for the debounce filter and one for the state register. A wake-up change reaches it on the (DB_WAKE+1)-th edge. A timer-driven transition lands on the edge that completes the state's duration, counted from the edge that entered the state. The outputs decode the state register, so they are valid just after that edge. The bench drives inputs and samples outputs on falling edges and counts every interval in whole edges from these rules. At each timeout it checks the output one edge before the transition and again on the transition edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [2:0] {
        ST_HOLD,
        ST_HANDSHAKE,
        ST_SHORT_CLOSED,
        ST_SHORT_OPEN,
        ST_LONG_CLOSED,
        ST_LONG_OPEN,
        ST_PULSE
    } wd_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/wdog_debounce.sv
module wdog_debounce #(
    parameter int unsigned SAMPLES = 3,
    parameter logic        INIT    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned CW = (SAMPLES < 2) ? 1 : $clog2(SAMPLES + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= INIT;
            run_q <= '0;
        end else if (din == dout) begin
            run_q <= '0;
        end else if (run_q == CW'(SAMPLES - 1)) begin
            dout  <= din;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_DB_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (din != dout && run_q != CW'(SAMPLES - 1)) |=> $stable(dout)); // R13
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
    parameter int unsigned TW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    assign expire = (cnt_q == limit - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_ena_qual.sv
module wdog_ena_qual #(
    parameter int unsigned NEED = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic good_trig,
    output logic qualified
);
    localparam int unsigned CW = $clog2(NEED + 1);

    logic [CW-1:0] seen_q;

    assign qualified = (seen_q == CW'(NEED));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (clear) begin
            seen_q <= '0;
        end else if (good_trig && !qualified) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    AST_QUAL_AFTER_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qualified) |-> $past(good_trig)); // R8
    AST_QUAL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !qualified); // R8
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int unsigned T_POR     = 201,
    parameter int unsigned T_MODESW  = 1112,
    parameter int unsigned T_SDIS    = 130,
    parameter int unsigned T_SEN     = 124,
    parameter int unsigned T_LDIS    = 71970,
    parameter int unsigned T_LEN     = 30002,
    parameter int unsigned T_RSTOUT  = 40,
    parameter int unsigned T_TRGMAX  = 45,
    parameter int unsigned DB_SHORT  = 3,
    parameter int unsigned DB_WAKE   = 96,
    parameter int unsigned ENA_TRIGS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic por_req,
    input  logic trig_in,
    input  logic mode_in,
    input  logic wake_in,
    output logic rst_out_n,
    output logic ena_out
);
    localparam int unsigned T_MAX = max2(max2(max2(T_POR, T_MODESW), max2(T_SDIS, T_SEN)),
                                         max2(max2(T_LDIS, T_LEN), T_RSTOUT));
    localparam int unsigned TW = $clog2(T_MAX + 1);
    localparam int unsigned LW = $clog2(T_TRGMAX + 1);

    wd_state_e     state_q, state_d;
    logic          trg_db, mode_db, wake_db;
    logic          trg_q, wake_q;
    logic          trg_rise, wake_edge, trg_err;
    logic [LW-1:0] low_q;
    logic [TW-1:0] limit;
    logic          tmr_restart, tmr_expire;
    logic          qual_clear, qual_ok, qualified;

    wdog_debounce #(.SAMPLES(DB_SHORT), .INIT(1'b1)) u_db_trig (
        .clk(clk), .rst_n(rst_n), .din(trig_in), .dout(trg_db));
    wdog_debounce #(.SAMPLES(DB_SHORT), .INIT(1'b1)) u_db_mode (
        .clk(clk), .rst_n(rst_n), .din(mode_in), .dout(mode_db));
    wdog_debounce #(.SAMPLES(DB_WAKE), .INIT(1'b0)) u_db_wake (
        .clk(clk), .rst_n(rst_n), .din(wake_in), .dout(wake_db));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trg_q  <= 1'b1;
            wake_q <= 1'b0;
        end else begin
            trg_q  <= trg_db;
            wake_q <= wake_db;
        end
    end

    assign trg_rise  = trg_db && !trg_q;
    assign wake_edge = wake_db ^ wake_q;

    // Length of the current trigger low inside the short open window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (state_q != ST_SHORT_OPEN || trg_db) begin
            low_q <= '0;
        end else if (low_q != LW'(T_TRGMAX)) begin
            low_q <= low_q + 1'b1;
        end
    end

    assign trg_err = (state_q == ST_SHORT_OPEN) && !trg_db && (low_q == LW'(T_TRGMAX));

    always_comb begin
        unique case (state_q)
            ST_HOLD:         limit = TW'(T_POR);
            ST_HANDSHAKE:    limit = TW'(T_MODESW);
            ST_SHORT_CLOSED: limit = TW'(T_SDIS);
            ST_SHORT_OPEN:   limit = TW'(T_SEN);
            ST_LONG_CLOSED:  limit = TW'(T_LDIS);
            ST_LONG_OPEN:    limit = TW'(T_LEN);
            ST_PULSE:        limit = TW'(T_RSTOUT);
            default:         limit = TW'(T_POR);
        endcase
    end

    wdog_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
        .limit(limit), .expire(tmr_expire));

    always_comb begin
        state_d = state_q;
        if (por_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:
                    if (tmr_expire) state_d = ST_HANDSHAKE;
                ST_HANDSHAKE:
                    if (!mode_db)        state_d = ST_SHORT_CLOSED;
                    else if (tmr_expire) state_d = ST_PULSE;
                ST_SHORT_CLOSED:
                    if (!trg_db)         state_d = ST_PULSE;
                    else if (mode_db)    state_d = ST_LONG_CLOSED;
                    else if (tmr_expire) state_d = ST_SHORT_OPEN;
                ST_SHORT_OPEN:
                    if (trg_rise)                    state_d = ST_SHORT_CLOSED;
                    else if (trg_err || tmr_expire)  state_d = ST_PULSE;
                    else if (mode_db)                state_d = ST_LONG_CLOSED;
                ST_LONG_CLOSED:
                    if (wake_edge || !trg_db) state_d = ST_PULSE;
                    else if (!mode_db)        state_d = ST_SHORT_CLOSED;
                    else if (tmr_expire)      state_d = ST_LONG_OPEN;
                ST_LONG_OPEN:
                    if (wake_edge || tmr_expire) state_d = ST_PULSE;
                    else if (trg_rise)           state_d = ST_LONG_CLOSED;
                    else if (!mode_db)           state_d = ST_SHORT_CLOSED;
                ST_PULSE:
                    if (tmr_expire) state_d = ST_HANDSHAKE;
                default:
                    state_d = ST_HOLD;
            endcase
        end
    end

    assign tmr_restart = (state_d != state_q) || por_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    assign qual_clear = (state_q == ST_HOLD) || (state_q == ST_PULSE);
    assign qual_ok    = (state_q == ST_SHORT_OPEN) && trg_rise && !por_req;

    wdog_ena_qual #(.NEED(ENA_TRIGS)) u_ena (
        .clk(clk), .rst_n(rst_n), .clear(qual_clear),
        .good_trig(qual_ok), .qualified(qualified));

    always_comb begin
        rst_out_n = !((state_q == ST_HOLD) || (state_q == ST_PULSE));
        ena_out   = qualified && ((state_q == ST_SHORT_CLOSED) || (state_q == ST_SHORT_OPEN));
    end

    AST_POR_FORCES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> (state_q == ST_HOLD)); // R12
    AST_EARLY_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHORT_CLOSED && !trg_db && !por_req) |=> (state_q == ST_PULSE)); // R6
    AST_WAKE_IN_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LONG_CLOSED || state_q == ST_LONG_OPEN) && wake_edge && !por_req)
        |=> (state_q == ST_PULSE)); // R11
    AST_PULSE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && tmr_expire && !por_req) |=> (state_q == ST_HANDSHAKE)); // R4
    AST_LONG_LOW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHORT_OPEN && !trg_db && low_q == LW'(T_TRGMAX) && !por_req)
        |=> (state_q == ST_PULSE)); // R7
endmodule

// File: tb/wdog_supervisor_tb.sv
module wdog_supervisor_tb;
    localparam int unsigned T_POR     = 20;
    localparam int unsigned T_MODESW  = 40;
    localparam int unsigned T_SDIS    = 30;
    localparam int unsigned T_SEN     = 25;
    localparam int unsigned T_LDIS    = 60;
    localparam int unsigned T_LEN     = 40;
    localparam int unsigned T_RSTOUT  = 8;
    localparam int unsigned T_TRGMAX  = 6;
    localparam int unsigned DB_SHORT  = 3;
    localparam int unsigned DB_WAKE   = 8;
    localparam int unsigned ENA_TRIGS = 3;

    logic clk = 1'b0;
    logic rst_n, por_req, trig_in, mode_in, wake_in;
    logic rst_out_n, ena_out;
    int   errors = 0;
    int   checks = 0;

    always #5 clk = ~clk;

    wdog_supervisor #(
        .T_POR(T_POR), .T_MODESW(T_MODESW), .T_SDIS(T_SDIS), .T_SEN(T_SEN),
        .T_LDIS(T_LDIS), .T_LEN(T_LEN), .T_RSTOUT(T_RSTOUT), .T_TRGMAX(T_TRGMAX),
        .DB_SHORT(DB_SHORT), .DB_WAKE(DB_WAKE), .ENA_TRIGS(ENA_TRIGS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .trig_in(trig_in),
        .mode_in(mode_in), .wake_in(wake_in), .rst_out_n(rst_out_n), .ena_out(ena_out));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Low pulse of len cycles started d edges after entering a closed state
    task automatic trig_pulse(input int d, input int len);
        step(d);
        trig_in = 1'b0;
        step(len);
        trig_in = 1'b1;
        step(DB_SHORT + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_req = 1'b0; trig_in = 1'b1; mode_in = 1'b1; wake_in = 1'b0;
        step(3);
        chk("R1 rst_out_n", rst_out_n, 1'b0);
        chk("R1 ena_out", ena_out, 1'b0);
        rst_n = 1'b1;

        step(T_POR - 1); chk("R2 hold", rst_out_n, 1'b0);
        step(1);         chk("R2 release", rst_out_n, 1'b1);

        step(T_MODESW - 1); chk("R3 before timeout", rst_out_n, 1'b1);
        step(1);            chk("R3 timeout", rst_out_n, 1'b0);
        step(T_RSTOUT - 1); chk("R4 pulse", rst_out_n, 1'b0);
        step(1);            chk("R4 pulse end", rst_out_n, 1'b1);

        mode_in = 1'b0;
        step(DB_SHORT + 1);                  // now in SHORT_CLOSED
        trig_in = 1'b0; step(DB_SHORT - 1); trig_in = 1'b1;   // glitch, ignored
        step(T_SDIS + T_SEN - 1 - (DB_SHORT - 1));
        chk("R13 glitch ignored / R5 before timeout", rst_out_n, 1'b1);
        step(1); chk("R5 open timeout", rst_out_n, 1'b0);
        step(T_RSTOUT); chk("R4 back to handshake", rst_out_n, 1'b1);
        step(1);                              // SHORT_CLOSED

        trig_pulse(T_SDIS + 2, 3); chk("R8 one trigger", ena_out, 1'b0);
        trig_pulse(T_SDIS + 2, 3); chk("R8 two triggers", ena_out, 1'b0);
        trig_pulse(T_SDIS + 2, 3); chk("R8 three triggers", ena_out, 1'b1);
        chk("R8 no reset", rst_out_n, 1'b1);
        trig_pulse(T_SDIS + 2, T_TRGMAX);
        chk("R7 max low accepted", rst_out_n, 1'b1);
        chk("R7 enable kept", ena_out, 1'b1);

        step(T_SDIS + 2); trig_in = 1'b0;
        step(DB_SHORT + T_TRGMAX); chk("R7 low at limit", rst_out_n, 1'b1);
        step(1); chk("R7 low too long", rst_out_n, 1'b0);
        chk("R8 cleared on error", ena_out, 1'b0);
        trig_in = 1'b1;
        step(T_RSTOUT + 1);
        trig_pulse(T_SDIS + 2, 3); chk("R8 count restarted", ena_out, 1'b0);

        step(2); trig_in = 1'b0;
        step(DB_SHORT); chk("R6 before effect", rst_out_n, 1'b1);
        step(1); chk("R6 early trigger", rst_out_n, 1'b0);
        trig_in = 1'b1;
        step(T_RSTOUT + 1); chk("R4 resync", rst_out_n, 1'b1);

        for (int i = 0; i < 3; i++) trig_pulse(T_SDIS + 2, 3);
        chk("R8 enable again", ena_out, 1'b1);
        mode_in = 1'b1;
        step(DB_SHORT); chk("R9 still short", ena_out, 1'b1);
        step(1);        chk("R9 long gates enable", ena_out, 1'b0);
        step(T_LDIS + T_LEN - 1); chk("R10 before long timeout", rst_out_n, 1'b1);
        step(1); chk("R10 long timeout", rst_out_n, 1'b0);

        mode_in = 1'b0;
        step(T_RSTOUT + 1); chk("R8 cleared by pulse", ena_out, 1'b0);
        mode_in = 1'b1;
        step(DB_SHORT + 1);                   // LONG_CLOSED
        trig_pulse(T_LDIS + 2, 3); chk("R10 long trigger accepted", rst_out_n, 1'b1);
        step(T_LDIS + T_LEN - 1); chk("R10 span restarted", rst_out_n, 1'b1);
        step(1); chk("R10 restarted timeout", rst_out_n, 1'b0);

        mode_in = 1'b0;
        step(T_RSTOUT + 1);
        mode_in = 1'b1;
        step(DB_SHORT + 1);                   // LONG_CLOSED
        step(5); wake_in = 1'b1;
        step(DB_WAKE); chk("R11 before wake", rst_out_n, 1'b1);
        step(1); chk("R11 wake in long closed", rst_out_n, 1'b0);

        mode_in = 1'b0;
        step(T_RSTOUT + 1);                   // SHORT_CLOSED
        wake_in = 1'b0;
        step(DB_WAKE + 4); chk("R11 wake ignored in short", rst_out_n, 1'b1);
        mode_in = 1'b1;
        step(DB_SHORT + 1);                   // LONG_CLOSED
        step(T_LDIS + 3); wake_in = 1'b1;
        step(DB_WAKE); chk("R11 before wake open", rst_out_n, 1'b1);
        step(1); chk("R11 wake in long open", rst_out_n, 1'b0);

        mode_in = 1'b0;
        step(T_RSTOUT + 1);
        mode_in = 1'b1;
        step(DB_SHORT + 1);                   // LONG_CLOSED
        mode_in = 1'b0;
        step(DB_SHORT + 1);                   // back to SHORT_CLOSED
        step(T_SDIS + T_SEN - 1); chk("R9 short timing again", rst_out_n, 1'b1);
        step(1); chk("R9 short timeout", rst_out_n, 1'b0);

        step(T_RSTOUT + 1);
        step(5); chk("R12 running", rst_out_n, 1'b1);
        por_req = 1'b1; step(1); por_req = 1'b0;
        chk("R12 forced hold", rst_out_n, 1'b0);
        step(T_POR - 1); chk("R12 hold length", rst_out_n, 1'b0);
        step(1); chk("R12 hold release", rst_out_n, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule